// File: doc/BRIEF.md
# I2C Master Receive Sequencer

This block is a bus master for a two-wire serial bus. A host runs it one bus phase at a time through single-cycle command strobes: open a transfer with a start condition, send an address byte, read a data byte, answer with an acknowledge or a not-acknowledge, and close with a stop condition. Each phase runs to completion by itself. At the end of every phase one shared interrupt flag is raised, which the host clears when it has handled the event.

Between phases the master owns the bus. It holds the clock line low and leaves the data line where the last phase put it. Both lines are open-drain: the block only reports when it pulls a line low, and it reads the wired data line back through `sdaIn`. Every clock period is split into four quarters of `QUARTER_CYCLES` system clocks each. Received bytes pass through a shift register into a holding buffer. The block flags a buffer-full condition, and it flags an overrun when a new byte completes before the previous one has been read.

Top module: `i2c_rx_master`

## Requirements
- R1: A start strobe, accepted while idle or between phases, produces a start condition: the data line falls while the clock line is released. When it completes, the clock is held low, `busy` drops and `irq` is set.
- R2: A `txWrite` strobe between phases sends `txData` MSB first over eight clock pulses. A ninth pulse releases the data line and samples it: `ackMissing` becomes 1 if the line was high and 0 if the slave pulled it low. `irq` is set at the end.
- R3: A receive strobe clocks in eight bits, MSB first, each one sampled while the clock is high. The byte is then moved to `rxData`, and `bufFull` and `irq` are set.
- R4: If a byte completes while `bufFull` is still 1, `overflow` is set and `rxData` keeps the older, unread byte.
- R5: A `rxRead` strobe clears `bufFull`.
- R6: An acknowledge strobe latches `ackBit` and drives it for one clock pulse: 0 pulls the data line low (ACK) and 1 releases it (NACK). `irq` is set at the end.
- R7: A stop strobe produces a stop condition: the data line rises while the clock is high. Both lines are then released, `stopSeen` and `irq` are set, and the next start clears `stopSeen`.
- R8: `irq` clears only on `irqClr` and `overflow` clears only on `ovfClr`. Other strobes, including `rxRead`, leave them unchanged.
- R9: Strobes that arrive while `busy` is 1 are ignored. While idle, every strobe except start is ignored.
- R10: Outside start and stop conditions, the data line changes only while the clock line is low.
- R11: After reset both lines are released, and `busy`, `bufFull`, `overflow`, `stopSeen` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start-condition strobe |
| txWrite | input | 1 | Address-byte send strobe |
| txData | input | 8 | Address byte, 7-bit address in [7:1] and R/W in [0] |
| cmdRecv | input | 1 | Receive-byte strobe |
| cmdAck | input | 1 | Acknowledge-phase strobe |
| ackBit | input | 1 | Acknowledge value: 0 = ACK, 1 = NACK |
| cmdStop | input | 1 | Stop-condition strobe |
| rxRead | input | 1 | Host has read rxData; clears bufFull |
| irqClr | input | 1 | Clears irq |
| ovfClr | input | 1 | Clears overflow |
| sdaIn | input | 1 | Sensed level of the wired data line |
| sclDriveLow | output | 1 | 1 pulls the clock line low |
| sdaDriveLow | output | 1 | 1 pulls the data line low |
| busy | output | 1 | A bus phase is running |
| rxData | output | 8 | Receive holding buffer |
| bufFull | output | 1 | Holding buffer holds an unread byte |
| overflow | output | 1 | A byte completed while the buffer was full |
| stopSeen | output | 1 | A stop condition has been generated |
| ackMissing | output | 1 | The last address byte was not acknowledged |
| irq | output | 1 | Phase-complete interrupt flag |

## Verification
The assertions check, on every cycle, the properties that hold whatever the stimulus. The data line stays still while the clock is high during address, data and acknowledge bits. A running receive phase cannot be cut short. Buffer-full, overflow and the kept byte follow each byte completion. `irq` never falls without its clear strobe. Only the bench's scenarios can show bit order on the wire and the slave-acknowledge result. They also cover the ACK/NACK value seen on the line, the start and stop edges as an outside observer sees them, and the ignored strobes, which the bench sends mid-phase and from idle.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HOLD,
    PH_START,
    PH_ADDR,
    PH_RECV,
    PH_ACK,
    PH_STOP
  } phase_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadTx;     // capture the address byte
    logic shiftTx;    // advance the transmit shifter
    logic sampleBit;  // shift in one received bit
    logic byteDone;   // eighth received bit is in place
    logic sampleAck;  // sample the slave acknowledge
    logic phaseEnd;   // any phase finished
    logic stopDone;   // stop condition finished
    logic startGo;    // start condition accepted
  } ctrl_strb_t;

endpackage

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
#(
  parameter int QUARTER_CYCLES = 125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       txWrite,
  input  logic       cmdRecv,
  input  logic       cmdAck,
  input  logic       ackBit,
  input  logic       cmdStop,
  input  logic       txMsb,
  output ctrl_strb_t strb,
  output logic       sclLow,
  output logic       sdaLow,
  output logic       busy
);

  localparam int DIV_W = (QUARTER_CYCLES > 1) ? $clog2(QUARTER_CYCLES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(QUARTER_CYCLES - 1);
  localparam logic [3:0] ADDR_LAST = 4'd8;
  localparam logic [3:0] RECV_LAST = 4'd7;

  phase_e          state;
  logic [DIV_W-1:0] divCnt;
  logic [1:0]      quarter;
  logic [3:0]      bitIdx;
  logic            ackLatched;
  logic            sdaHoldLow;
  logic            repStart;
  logic            tick;
  logic            lastQuarter;
  logic [3:0]      lastBit;
  logic            phaseEnd;
  logic            pulseLow;

  assign tick        = (divCnt == DIV_LAST);
  assign lastQuarter = tick && (quarter == 2'd3);
  assign busy        = (state != PH_IDLE) && (state != PH_HOLD);
  assign pulseLow    = (quarter == 2'd0) || (quarter == 2'd3);

  always_comb begin
    case (state)
      PH_ADDR: lastBit = ADDR_LAST;
      PH_RECV: lastBit = RECV_LAST;
      default: lastBit = 4'd0;
    endcase
  end

  assign phaseEnd = busy && lastQuarter && (bitIdx == lastBit);

  // Bus line drive per phase and quarter
  always_comb begin
    sclLow = 1'b0;
    sdaLow = 1'b0;
    case (state)
      PH_HOLD: begin
        sclLow = 1'b1;
        sdaLow = sdaHoldLow;
      end
      PH_START: begin
        sclLow = (quarter == 2'd0) ? repStart : (quarter == 2'd3);
        sdaLow = quarter[1];
      end
      PH_ADDR: begin
        sclLow = pulseLow;
        sdaLow = (bitIdx < ADDR_LAST) ? !txMsb : 1'b0;
      end
      PH_RECV: begin
        sclLow = pulseLow;
        sdaLow = 1'b0;
      end
      PH_ACK: begin
        sclLow = pulseLow;
        sdaLow = !ackLatched;
      end
      PH_STOP: begin
        sclLow = (quarter == 2'd0);
        sdaLow = !quarter[1];
      end
      default: begin
        sclLow = 1'b0;
        sdaLow = 1'b0;
      end
    endcase
  end

  // Strobes to the datapath
  always_comb begin
    strb           = '0;
    strb.startGo   = cmdStart && !busy;
    strb.loadTx    = (state == PH_HOLD) && !cmdStart && txWrite;
    strb.shiftTx   = (state == PH_ADDR) && lastQuarter && (bitIdx < ADDR_LAST);
    strb.sampleBit = (state == PH_RECV) && tick && (quarter == 2'd2);
    strb.sampleAck = (state == PH_ADDR) && tick && (quarter == 2'd2) && (bitIdx == ADDR_LAST);
    strb.byteDone  = (state == PH_RECV) && phaseEnd;
    strb.phaseEnd  = phaseEnd;
    strb.stopDone  = (state == PH_STOP) && phaseEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= PH_IDLE;
      divCnt     <= '0;
      quarter    <= '0;
      bitIdx     <= '0;
      ackLatched <= 1'b1;
      sdaHoldLow <= 1'b0;
      repStart   <= 1'b0;
    end else begin
      case (state)
        PH_IDLE: begin
          if (cmdStart) begin
            state    <= PH_START;
            repStart <= 1'b0;
            divCnt   <= '0;
            quarter  <= '0;
            bitIdx   <= '0;
          end
        end
        PH_HOLD: begin
          divCnt  <= '0;
          quarter <= '0;
          bitIdx  <= '0;
          if (cmdStart) begin
            state    <= PH_START;
            repStart <= 1'b1;
          end else if (txWrite) begin
            state <= PH_ADDR;
          end else if (cmdRecv) begin
            state <= PH_RECV;
          end else if (cmdAck) begin
            state      <= PH_ACK;
            ackLatched <= ackBit;
          end else if (cmdStop) begin
            state <= PH_STOP;
          end
        end
        default: begin
          if (tick) begin
            divCnt  <= '0;
            quarter <= quarter + 2'd1;
            if (quarter == 2'd3) begin
              if (bitIdx == lastBit) begin
                bitIdx     <= '0;
                sdaHoldLow <= sdaLow;
                state      <= (state == PH_STOP) ? PH_IDLE : PH_HOLD;
              end else begin
                bitIdx <= bitIdx + 4'd1;
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
      endcase
    end
  end

  // R10
  sda_quiet_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sclLow && !$past(sclLow) && (state == $past(state)) &&
     (state == PH_ADDR || state == PH_RECV || state == PH_ACK))
    |-> (sdaLow == $past(sdaLow)));

  // R6
  ack_level_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_ACK && $past(state) == PH_ACK) |-> $stable(sdaLow));

  // R9
  recv_not_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_RECV && !phaseEnd) |=> (state == PH_RECV));

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stopDone |=> (!sclLow && !sdaLow && !busy));

endmodule

// File: rtl/i2c_rx_datapath.sv
module i2c_rx_datapath
  import i2c_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctrl_strb_t strb,
  input  logic [7:0] txData,
  input  logic       sdaIn,
  input  logic       rxRead,
  input  logic       irqClr,
  input  logic       ovfClr,
  output logic       txMsb,
  output logic [7:0] rxData,
  output logic       bufFull,
  output logic       overflow,
  output logic       stopSeen,
  output logic       ackMissing,
  output logic       irq
);

  logic [7:0] txShift;
  logic [7:0] rxShift;

  assign txMsb = txShift[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift    <= '0;
      rxShift    <= '0;
      rxData     <= '0;
      bufFull    <= 1'b0;
      overflow   <= 1'b0;
      stopSeen   <= 1'b0;
      ackMissing <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (strb.loadTx)       txShift <= txData;
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b0};

      if (strb.sampleBit) rxShift <= {rxShift[6:0], sdaIn};
      if (strb.sampleAck) ackMissing <= sdaIn;

      if (strb.byteDone) begin
        bufFull <= 1'b1;
        if (!bufFull) rxData <= rxShift;
      end else if (rxRead) begin
        bufFull <= 1'b0;
      end

      if (strb.byteDone && bufFull) overflow <= 1'b1;
      else if (ovfClr)              overflow <= 1'b0;

      if (strb.phaseEnd) irq <= 1'b1;
      else if (irqClr)   irq <= 1'b0;

      if (strb.stopDone)     stopSeen <= 1'b1;
      else if (strb.startGo) stopSeen <= 1'b0;
    end
  end

  // R4
  ovf_on_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteDone && bufFull) |=> overflow);

  // R4
  keep_unread_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteDone && bufFull) |=> $stable(rxData));

  // R3
  full_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteDone |=> (bufFull && irq));

  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && !strb.byteDone) |=> !bufFull);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq);

endmodule

// File: rtl/i2c_rx_master.sv
module i2c_rx_master
  import i2c_rx_pkg::*;
#(
  parameter int QUARTER_CYCLES = 125
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       txWrite,
  input  logic [7:0] txData,
  input  logic       cmdRecv,
  input  logic       cmdAck,
  input  logic       ackBit,
  input  logic       cmdStop,
  input  logic       rxRead,
  input  logic       irqClr,
  input  logic       ovfClr,
  input  logic       sdaIn,
  output logic       sclDriveLow,
  output logic       sdaDriveLow,
  output logic       busy,
  output logic [7:0] rxData,
  output logic       bufFull,
  output logic       overflow,
  output logic       stopSeen,
  output logic       ackMissing,
  output logic       irq
);

  ctrl_strb_t strb;
  logic       txMsb;

  i2c_rx_ctrl #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdStart(cmdStart),
    .txWrite (txWrite),
    .cmdRecv (cmdRecv),
    .cmdAck  (cmdAck),
    .ackBit  (ackBit),
    .cmdStop (cmdStop),
    .txMsb   (txMsb),
    .strb    (strb),
    .sclLow  (sclDriveLow),
    .sdaLow  (sdaDriveLow),
    .busy    (busy)
  );

  i2c_rx_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .txData    (txData),
    .sdaIn     (sdaIn),
    .rxRead    (rxRead),
    .irqClr    (irqClr),
    .ovfClr    (ovfClr),
    .txMsb     (txMsb),
    .rxData    (rxData),
    .bufFull   (bufFull),
    .overflow  (overflow),
    .stopSeen  (stopSeen),
    .ackMissing(ackMissing),
    .irq       (irq)
  );

endmodule

// File: tb/i2c_rx_master_tb.sv
module i2c_rx_master_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdStart = 0, txWrite = 0, cmdRecv = 0, cmdAck = 0, cmdStop = 0;
  logic       ackBit = 1'b0, rxRead = 0, irqClr = 0, ovfClr = 0;
  logic [7:0] txData = 8'h00;
  logic       sdaIn;
  logic       sclDriveLow, sdaDriveLow, busy, bufFull, overflow, stopSeen, ackMissing, irq;
  logic [7:0] rxData;

  always #10 clk = ~clk;

  i2c_rx_master #(.QUARTER_CYCLES(3)) u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .txWrite(txWrite), .txData(txData),
    .cmdRecv(cmdRecv), .cmdAck(cmdAck), .ackBit(ackBit), .cmdStop(cmdStop),
    .rxRead(rxRead), .irqClr(irqClr), .ovfClr(ovfClr), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .busy(busy), .rxData(rxData),
    .bufFull(bufFull), .overflow(overflow), .stopSeen(stopSeen), .ackMissing(ackMissing),
    .irq(irq)
  );

  // Slave model and bus monitor
  logic [1:0]  slaveMode = 2'd0;   // 0 quiet, 1 acknowledge address, 2 send byte
  logic [7:0]  slaveByte = 8'h00;
  logic        monClr = 1'b0;
  logic [7:0]  fallCnt;
  logic [15:0] monBits;
  int          monCount, startDet, stopDet;
  logic        prevScl, prevSda, slaveLow, sclLine, sdaLine;

  assign slaveLow = ((slaveMode == 2'd1) && (fallCnt == 8'd8)) ||
                    ((slaveMode == 2'd2) && (fallCnt < 8'd8) && !slaveByte[3'(7 - fallCnt)]);
  assign sclLine = !sclDriveLow;
  assign sdaLine = !(sdaDriveLow || slaveLow);
  assign sdaIn   = sdaLine;

  always @(posedge clk) begin
    if (!rstN || monClr) begin
      prevScl  <= sclLine;
      prevSda  <= sdaLine;
      fallCnt  <= '0;
      monBits  <= '0;
      monCount <= 0;
      startDet <= 0;
      stopDet  <= 0;
    end else begin
      prevScl <= sclLine;
      prevSda <= sdaLine;
      if (sclLine && !prevScl) begin
        monBits  <= {monBits[14:0], sdaLine};
        monCount <= monCount + 1;
      end
      if (!sclLine && prevScl) fallCnt <= fallCnt + 8'd1;
      if (sclLine && prevScl && prevSda && !sdaLine) startDet <= startDet + 1;
      if (sclLine && prevScl && !prevSda && sdaLine) stopDet <= stopDet + 1;
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearMon();
    @(negedge clk) monClr = 1'b1;
    @(negedge clk) monClr = 1'b0;
  endtask

  // 0 start, 1 txWrite, 2 recv, 3 ack, 4 stop, 5 rxRead, 6 irqClr, 7 ovfClr
  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: cmdStart = 1'b1;
      1: txWrite  = 1'b1;
      2: cmdRecv  = 1'b1;
      3: cmdAck   = 1'b1;
      4: cmdStop  = 1'b1;
      5: rxRead   = 1'b1;
      6: irqClr   = 1'b1;
      default: ovfClr = 1'b1;
    endcase
    @(negedge clk);
    {cmdStart, txWrite, cmdRecv, cmdAck, cmdStop, rxRead, irqClr, ovfClr} = '0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic runPhase(input int which);
    clearMon();
    strobe(which);
    waitIdle();
  endtask

  // {ackBit, data byte}
  localparam logic [8:0] VEC [4] = '{9'h0A5, 9'h03C, 9'h081, 9'h1FE};

  task automatic runTests();
    // R11 reset state
    chk("R11 scl", sclDriveLow, 0);
    chk("R11 sda", sdaDriveLow, 0);
    chk("R11 flags", {busy, bufFull, overflow, stopSeen, irq}, 0);

    // R9 receive strobe while idle is ignored
    strobe(2);
    repeat (5) @(negedge clk);
    chk("R9 idle recv busy", busy, 0);
    chk("R9 idle recv irq", irq, 0);

    // R1 start condition
    runPhase(0);
    chk("R1 start edge", startDet, 1);
    chk("R1 scl held", sclDriveLow, 1);
    chk("R1 irq", irq, 1);
    repeat (4) @(negedge clk);
    chk("R8 irq sticky", irq, 1);
    strobe(6);
    chk("R8 irq cleared", irq, 0);

    // R2 address with slave acknowledge
    txData = 8'hA3;
    slaveMode = 2'd1;
    clearMon();
    strobe(1);
    waitIdle();
    slaveMode = 2'd0;
    chk("R2 bit count", monCount, 9);
    chk("R2 address bits", monBits[8:1], 8'hA3);
    chk("R2 ack seen", ackMissing, 0);
    chk("R2 irq", irq, 1);
    strobe(6);

    // R3 R5 R6 vector walk
    for (int i = 0; i < 4; i++) begin
      slaveByte = VEC[i][7:0];
      slaveMode = 2'd2;
      runPhase(2);
      slaveMode = 2'd0;
      chk("R3 data", rxData, VEC[i][7:0]);
      chk("R3 full", bufFull, 1);
      chk("R3 irq", irq, 1);
      chk("R4 no overflow", overflow, 0);
      strobe(5);
      chk("R5 read clears", bufFull, 0);
      strobe(6);
      ackBit = VEC[i][8];
      runPhase(3);
      chk("R6 line level", monBits[0], VEC[i][8]);
      chk("R6 irq", irq, 1);
      strobe(6);
    end

    // R4 overflow, with a stop strobe sent mid-phase (R9)
    slaveByte = 8'h11;
    slaveMode = 2'd2;
    runPhase(2);
    slaveByte = 8'h22;
    clearMon();
    strobe(2);
    repeat (10) @(negedge clk);
    strobe(4);
    waitIdle();
    slaveMode = 2'd0;
    chk("R4 overflow", overflow, 1);
    chk("R4 keeps old", rxData, 8'h11);
    chk("R9 stop ignored", stopSeen, 0);
    chk("R9 still holding", sclDriveLow, 1);
    strobe(5);
    chk("R5 read", bufFull, 0);
    chk("R8 read keeps irq", irq, 1);
    chk("R8 read keeps ovf", overflow, 1);
    strobe(7);
    chk("R8 ovf cleared", overflow, 0);
    strobe(6);

    // R7 NACK then stop
    ackBit = 1'b1;
    runPhase(3);
    runPhase(4);
    chk("R7 stop edge", stopDet, 1);
    chk("R7 stopSeen", stopSeen, 1);
    chk("R7 irq", irq, 1);
    chk("R7 lines free", {sclDriveLow, sdaDriveLow}, 0);
    strobe(6);

    // R7 next start clears stopSeen; R2 address not acknowledged
    runPhase(0);
    chk("R7 cleared", stopSeen, 0);
    txData = 8'h5D;
    runPhase(1);
    chk("R2 address bits nack", monBits[8:1], 8'h5D);
    chk("R2 no ack", ackMissing, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    fork
      runTests();
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule